// File: doc/BRIEF.md
# Monotonic-switching SAR bit register

This block sequences a 10-bit successive-approximation conversion for a fully-differential converter whose capacitor arrays use monotonic switching. While the sample input is high, every bottom-plate control on both arrays sits at the high (supply) level. When sampling ends, a one-hot pointer is loaded at the most significant position. The first comparison is then made with no capacitor moved. Each resolved comparator decision is written into the bit cell the pointer selects, and the pointer moves one place toward the least significant bit.

A bit cell holds both of its differential controls high until its decision arrives. It then pulls exactly one of them low: the control on the array whose input was higher. It keeps that state until the next sampling phase. A single set of cells drives both arrays. When the tenth decision lands, the end-of-conversion flag rises, later decisions are ignored, and the result is offered on a valid/ready output.

The comparator pair and the sample input are registered on entry. A decision counts when the exclusive-OR of the two comparator outputs goes from low to high. A bit cell therefore updates on the second rising clock edge after the comparator pair resolves. The result port follows valid/ready rules with this back-pressure behaviour: conversion never waits for `res_ready`, a result that has not been accepted stays stable, and the next completed conversion replaces it.

Top module: `sar_mono_ctrl`

## Requirements
- R1: While `rst_n` is low, all bits of `ctl_p` and `ctl_n` are 1, `eoc` is 0 and `res_valid` is 0.
- R2: From two cycles after `sample` rises until it falls, every control on both arrays is 1 and `eoc` is 0. This holds even when a conversion is aborted partway through.
- R3: After `sample` falls, no control leaves the all-high state until the first resolved decision. That decision is applied to the most significant bit (index N-1).
- R4: Each resolved decision, meaning a rising edge of `cmp_p` XOR `cmp_n`, settles exactly one bit pair. Bits settle strictly from index N-1 down to 0, and all bits below the current one stay high.
- R5: A decision with `cmp_p` high is bit value 1 and makes the pair `ctl_p[i]`=0, `ctl_n[i]`=1. A decision with `cmp_n` high is bit value 0 and makes `ctl_p[i]`=1, `ctl_n[i]`=0. Both controls of a pair are never low together.
- R6: A settled pair keeps its value until the next sampling phase. After a full conversion, `ctl_n` equals the result code and `ctl_p` equals its bitwise inverse.
- R7: `eoc` rises on the edge that settles bit 0 and stays high until sampling starts again. While `eoc` is high, further comparator decisions change no control and no output.
- R8: `res_code` (bit i is decision i) and `res_valid` are loaded on the same edge that raises `eoc`. While `res_valid` is high and `res_ready` is low, the code stays stable unless a new conversion completes. A cycle with `res_valid` and `res_ready` both high clears `res_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample | input | 1 | High during the sampling phase; its falling edge starts a conversion |
| cmp_p | input | 1 | Comparator output, high when the positive side is higher |
| cmp_n | input | 1 | Comparator output, high when the negative side is higher |
| ctl_p | output | N | Bottom-plate controls of the positive array (1 = supply, 0 = ground) |
| ctl_n | output | N | Bottom-plate controls of the negative array (1 = supply, 0 = ground) |
| eoc | output | 1 | End of conversion |
| res_code | output | N | Converted code |
| res_valid | output | 1 | Result valid |
| res_ready | input | 1 | Result accepted by the consumer |

## Verification
The hardest cases to reach are decisions that arrive when no bit should take them: after the last bit has settled, or after a conversion has been cut short by a new sampling phase. The bench gets there with a behavioural model of the two arrays. It drives the comparator from the live control outputs and the input code, sweeps every one of the 1024 input codes, and then sends extra resolved decisions after end of conversion. It also raises `sample` in the middle of a conversion and checks that the arrays return to the all-high state.

// File: rtl/sar_mono_pkg.sv
package sar_mono_pkg;

  // One resolved comparator decision: fire marks the event, val is the bit.
  typedef struct packed {
    logic fire;
    logic val;
  } sar_dec_t;

  // Differential pair state, ordered {positive control, negative control}.
  typedef enum logic [1:0] {
    PAIR_IDLE = 2'b11,
    PAIR_ONE  = 2'b01,
    PAIR_ZERO = 2'b10
  } pair_e;

endpackage

// File: rtl/sar_front.sv
module sar_front
  import sar_mono_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     sample,
  input  logic     cmp_p,
  input  logic     cmp_n,
  output sar_dec_t dec,
  output logic     hold,
  output logic     arm
);

  logic cmp_p_q, cmp_n_q, resolved_q, sample_q, sample_qq;
  logic resolved;

  // The comparator has resolved only when its two outputs differ.
  assign resolved = cmp_p_q ^ cmp_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_p_q    <= 1'b0;
      cmp_n_q    <= 1'b0;
      resolved_q <= 1'b0;
      sample_q   <= 1'b0;
      sample_qq  <= 1'b0;
    end else begin
      cmp_p_q    <= cmp_p;
      cmp_n_q    <= cmp_n;
      resolved_q <= resolved;
      sample_q   <= sample;
      sample_qq  <= sample_q;
    end
  end

  assign dec.fire = resolved & ~resolved_q;
  assign dec.val  = cmp_p_q;
  assign hold     = sample_q;
  assign arm      = ~sample_q & sample_qq;

endmodule

// File: rtl/sar_pointer.sv
module sar_pointer #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic         arm,
  input  logic         fire,
  output logic [N-1:0] ptr,
  output logic         done
);

  localparam logic [N-1:0] TOP = {1'b1, {(N-1){1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr  <= '0;
      done <= 1'b0;
    end else if (hold) begin
      ptr  <= '0;
      done <= 1'b0;
    end else if (arm) begin
      ptr  <= TOP;
      done <= 1'b0;
    end else if (fire && (ptr != '0)) begin
      ptr <= ptr >> 1;
      if (ptr[0]) done <= 1'b1;
    end
  end

endmodule

// File: rtl/sar_bit_cell.sv
module sar_bit_cell
  import sar_mono_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic sel,
  input  logic val,
  output logic ctl_p,
  output logic ctl_n
);

  pair_e st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= PAIR_IDLE;
    end else if (clr) begin
      st <= PAIR_IDLE;
    end else if (sel && st == PAIR_IDLE) begin
      st <= val ? PAIR_ONE : PAIR_ZERO;
    end
  end

  assign {ctl_p, ctl_n} = st;

endmodule

// File: rtl/sar_result.sv
module sar_result #(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [N-1:0] code_in,
  input  logic         ready,
  output logic [N-1:0] code,
  output logic         valid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code  <= '0;
      valid <= 1'b0;
    end else if (load) begin
      code  <= code_in;
      valid <= 1'b1;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end

endmodule

// File: rtl/sar_mono_ctrl.sv
module sar_mono_ctrl
  import sar_mono_pkg::*;
#(
  parameter int N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sample,
  input  logic         cmp_p,
  input  logic         cmp_n,
  output logic [N-1:0] ctl_p,
  output logic [N-1:0] ctl_n,
  output logic         eoc,
  output logic [N-1:0] res_code,
  output logic         res_valid,
  input  logic         res_ready
);

  sar_dec_t     dec;
  logic         hold, arm, clr;
  logic [N-1:0] ptr;
  logic         last_fire;
  logic [N-1:0] code_next;

  sar_front u_front (
    .clk   (clk),
    .rst_n (rst_n),
    .sample(sample),
    .cmp_p (cmp_p),
    .cmp_n (cmp_n),
    .dec   (dec),
    .hold  (hold),
    .arm   (arm)
  );

  sar_pointer #(.N(N)) u_ptr (
    .clk  (clk),
    .rst_n(rst_n),
    .hold (hold),
    .arm  (arm),
    .fire (dec.fire),
    .ptr  (ptr),
    .done (eoc)
  );

  assign clr = hold | arm;

  for (genvar i = 0; i < N; i++) begin : g_cell
    sar_bit_cell u_cell (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (clr),
      .sel  (ptr[i] & dec.fire),
      .val  (dec.val),
      .ctl_p(ctl_p[i]),
      .ctl_n(ctl_n[i])
    );
  end

  // The last bit settles on the same edge that loads the result, so take it live.
  assign last_fire = dec.fire & ptr[0] & ~clr;
  assign code_next = {~ctl_p[N-1:1], dec.val};

  sar_result #(.N(N)) u_res (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (last_fire),
    .code_in(code_next),
    .ready  (res_ready),
    .code   (res_code),
    .valid  (res_valid)
  );

endmodule

// File: rtl/sar_mono_ctrl_chk.sv
module sar_mono_ctrl_chk #(
  parameter int N = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sample,
  input logic [N-1:0] ctl_p,
  input logic [N-1:0] ctl_n,
  input logic         eoc,
  input logic [N-1:0] res_code,
  input logic         res_valid,
  input logic         res_ready
);

  logic [N-1:0] unsettled;
  assign unsettled = ctl_p & ctl_n;

  assert_pair_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((~ctl_p & ~ctl_n) == '0));

  assert_msb_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (((unsettled + {{(N-1){1'b0}}, 1'b1}) & unsettled) == '0));

  assert_one_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones($past(unsettled) & ~unsettled) <= 1));

  assert_sampling_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && $past(sample)) |=> ((&ctl_p) && (&ctl_n) && !eoc));

  assert_settled_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (eoc && $past(eoc)) |-> ($stable(ctl_p) && $stable(ctl_n)));

  assert_eoc_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eoc |-> (unsettled == '0));

  assert_res_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && ($stable(res_code) || $rose(eoc))));

  assert_res_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc) |-> res_valid);

endmodule

bind sar_mono_ctrl sar_mono_ctrl_chk #(.N(N)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sample   (sample),
  .ctl_p    (ctl_p),
  .ctl_n    (ctl_n),
  .eoc      (eoc),
  .res_code (res_code),
  .res_valid(res_valid),
  .res_ready(res_ready)
);

// File: tb/sar_mono_ctrl_tb.sv
module sar_mono_ctrl_tb;

  localparam int N        = 10;
  localparam int CLK_PER  = 10;
  localparam int WD_LIMIT = 150000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sample = 1'b0;
  logic         cmp_p = 1'b0;
  logic         cmp_n = 1'b0;
  logic         res_ready = 1'b0;
  logic [N-1:0] ctl_p, ctl_n, res_code;
  logic         eoc, res_valid;

  int checks = 0;
  int errors = 0;

  always #(CLK_PER/2) clk = ~clk;

  sar_mono_ctrl #(.N(N)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .sample   (sample),
    .cmp_p    (cmp_p),
    .cmp_n    (cmp_n),
    .ctl_p    (ctl_p),
    .ctl_n    (ctl_n),
    .eoc      (eoc),
    .res_code (res_code),
    .res_valid(res_valid),
    .res_ready(res_ready)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Runs sampling plus up to stop_after decisions; the comparator is modelled
  // from the input code and the live control outputs of both arrays.
  task automatic run_conv(input int x, input int stop_after);
    int d;
    bit bitv;
    int e;
    sample = 1'b1;
    cmp_p = 1'b0; cmp_n = 1'b0;
    tick(3);
    check((&ctl_p) && (&ctl_n) && !eoc, "R2", "controls high while sampling",
          int'(ctl_p & ctl_n), (1 << N) - 1);
    sample = 1'b0;
    tick(3);
    check((&ctl_p) && (&ctl_n), "R3", "no switching before first decision",
          int'(ctl_p & ctl_n), (1 << N) - 1);
    for (int i = N - 1; i >= 0 && (N - 1 - i) < stop_after; i--) begin
      cmp_p = 1'b0; cmp_n = 1'b0;
      tick(2);
      d = 2 * x - ((1 << N) - 1);
      for (int j = 0; j < N; j++) begin
        if (!ctl_p[j]) d = d - (1 << j);
        if (!ctl_n[j]) d = d + (1 << j);
      end
      bitv = (d > 0);
      cmp_p = bitv; cmp_n = !bitv;
      tick(3);
      e = (x >> i) & 1;
      check(ctl_p[i] == !e[0] && ctl_n[i] == e[0], "R5", "pair value",
            int'({ctl_p[i], ctl_n[i]}), e == 1 ? 1 : 2);
      check(int'(ctl_p & ctl_n) == ((1 << i) - 1), "R4", "settled prefix",
            int'(ctl_p & ctl_n), (1 << i) - 1);
    end
    cmp_p = 1'b0; cmp_n = 1'b0;
  endtask

  initial begin
    #(CLK_PER * WD_LIMIT);
    errors++;
    $display("FAIL watchdog R7 actual=%0d expected=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] xv;
    logic [N-1:0] keep_p, keep_n;
    tick(3);
    // R1: reset state
    check((&ctl_p) && (&ctl_n), "R1", "controls at reset", int'(ctl_p & ctl_n), (1 << N) - 1);
    check(!eoc && !res_valid, "R1", "eoc and res_valid at reset", int'({eoc, res_valid}), 0);
    rst_n = 1'b1;
    tick(2);

    // Abort partway: R2
    run_conv(700, 4);
    check(ctl_p[N-1:N-4] == 4'b0101 && ctl_n[N-1:N-4] == 4'b1010, "R5",
          "partial conversion of 700", int'(ctl_n[N-1:N-4]), 10);
    sample = 1'b1;
    tick(3);
    check((&ctl_p) && (&ctl_n) && !eoc && !res_valid, "R2", "abort restores all-high",
          int'(ctl_p & ctl_n), (1 << N) - 1);

    // Exhaustive sweep over every input code
    for (int x = 0; x < (1 << N); x++) begin
      xv = x[N-1:0];
      run_conv(x, N);
      check(eoc == 1'b1, "R7", "eoc after last bit", int'(eoc), 1);
      check(ctl_n == xv && ctl_p == ~xv, "R6", "final pairs", int'(ctl_n), x);
      check(res_valid && res_code == xv, "R8", "result code", int'(res_code), x);
      tick(2);
      check(res_valid && res_code == xv, "R8", "result held without ready",
            int'(res_code), x);
      if ((x % 64) == 5) begin
        keep_p = ctl_p; keep_n = ctl_n;
        cmp_p = 1'b0; cmp_n = 1'b0; tick(2);
        cmp_p = ~xv[0]; cmp_n = xv[0]; tick(3);
        cmp_p = 1'b0; cmp_n = 1'b0; tick(2);
        cmp_p = xv[0]; cmp_n = ~xv[0]; tick(3);
        check(ctl_p == keep_p && ctl_n == keep_n && eoc && res_code == xv, "R7",
              "decision after eoc ignored", int'(ctl_n), int'(keep_n));
        cmp_p = 1'b0; cmp_n = 1'b0;
      end
      res_ready = 1'b1;
      tick(1);
      res_ready = 1'b0;
      check(!res_valid, "R8", "handshake clears valid", int'(res_valid), 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule